// File: doc/BRIEF.md
# Mixed-Decay Chopping Current Controller

This block drives the state of one H-bridge phase during constant-current chopping. A chopping period is a fixed run of reference ticks. Each period normally opens in charge. When the current-reached flag arrives, the phase drops into slow decay. It then switches to fast decay at a programmable point late in the period, and stays in fast decay until the period ends. A 2-bit selector sets what share of the period belongs to fast decay. At the end of a fast-decay interval, a second comparator flag reports whether the current is still above its target. If it is, the next period skips charge and starts directly in decay. This is the charge-cancel rule.

A step-clock event does not restart the period at once. It arms a restart, and the next reference tick then begins a fresh period in charge, so a new current comparison is made right away. For a short blanking window after every state change or period start, the current-reached flag is ignored. This masks switching noise on the comparator. When the enable input is low, the phase is turned off and the tick counter is cleared. The comparators, the oscillator and the reference DAC lie outside the block; their results arrive as flags synchronous to the system clock.

Top module: `chopCtrl`

## Requirements
- R1: After reset the drive state is OFF (code 0) and the period strobe is low. The state stays OFF until a reference tick arrives with enable high.
- R2: The period strobe is high for one cycle, together with the first state of a new period. Without a step event, each period spans PERIOD_TICKS reference ticks (tick index 0 to PERIOD_TICKS-1).
- R3: With enable high, the first tick starts a period in CHARGE (code 1). A period also starts in CHARGE whenever the previous period did not end in FAST with the monitor flag high.
- R4: In CHARGE, a current-reached flag that is honoured moves the state to SLOW (code 2) if the tick index is below the switch point, and to FAST (code 3) if it is at or past it.
- R5: The switch point is a tick index set by the selector: 00 gives 7, 01 gives 5, 10 gives 2 and 11 gives 0 (fast share 1/8, 3/8, 6/8, 8/8 of an 8-tick period, rounded to the nearest tick). SLOW becomes FAST one cycle after the index reaches the switch point, and FAST holds until the period ends.
- R6: If the state is FAST on the tick that ends a period and the monitor flag is high on that tick, the new period starts in SLOW, or in FAST when the selector is 11.
- R7: A step pulse leaves the state and the tick index unchanged until the next tick. That tick restarts the period at index 0 in CHARGE with the strobe, whatever the monitor flag shows.
- R8: After each state change and each period start, the current-reached flag is ignored for BLANK_CYCLES system cycles.
- R9: Enable low forces OFF on the next cycle and clears the tick index. Ticks and flags have no effect while enable is low. After enable returns, the next tick starts a period at index 0 in CHARGE.
- R10: The current-reached flag has no effect in SLOW or FAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle reference oscillator tick |
| stepIn | input | 1 | One-cycle step-clock event |
| enableIn | input | 1 | High to run; low forces OFF and clears the counter |
| decaySel | input | 2 | Decay timing selector (fast-decay share of the period) |
| nfIn | input | 1 | Current-reached comparator flag |
| rnfIn | input | 1 | Current-above-target monitor flag, sampled at period end |
| driveState | output | 2 | 0 OFF, 1 CHARGE, 2 SLOW, 3 FAST |
| periodStart | output | 1 | One-cycle strobe at the start of each period |

## Verification
The bench builds the block with an 8-tick period and a 4-cycle blanking window. The short window lets a test hold the current-reached flag high and observe both the last ignored cycle and the first honoured one. The 8-tick period makes each of the four switch points land on an exact tick index, so the tests can walk every selector setting tick by tick. They can also reach a late current-reached flag past the switch point, a charge-cancelled period in both SLOW and FAST, and a step restart that interrupts a period partway through.

// File: rtl/chopPkg.sv
package chopPkg;

  typedef enum logic [1:0] {
    DRV_OFF    = 2'd0,
    DRV_CHARGE = 2'd1,
    DRV_SLOW   = 2'd2,
    DRV_FAST   = 2'd3
  } driveE;

  // strobes from sequencer to timing datapath
  typedef struct packed {
    logic newPeriod;  // restart tick index at zero
    logic reload;     // restart blanking window
    logic halt;       // disabled: clear everything
  } ctrlStrobeS;

  // fast-decay share of the period, in eighths
  function automatic logic [3:0] decayEighths(input logic [1:0] sel);
    case (sel)
      2'd0:    decayEighths = 4'd1;
      2'd1:    decayEighths = 4'd3;
      2'd2:    decayEighths = 4'd6;
      default: decayEighths = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/chopTimer.sv
module chopTimer
  import chopPkg::*;
#(
  parameter int unsigned PERIOD_TICKS = 8,
  parameter int unsigned BLANK_CYCLES = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       stepIn,
  input  logic [1:0] decaySel,
  input  ctrlStrobeS strobe,
  output logic       wrapDue,
  output logic       restartPend,
  output logic       pastSwitch,
  output logic       switchAtZero,
  output logic       blankActive
);

  localparam int unsigned IDX_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
  localparam int unsigned SW_W  = $clog2(PERIOD_TICKS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PERIOD_TICKS - 1);

  logic [IDX_W-1:0] tickIdx;
  logic [SW_W-1:0]  switchTick;
  logic [31:0]      fastTicks;

  // tick index within the period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tickIdx <= '0;
    else if (strobe.halt)      tickIdx <= '0;
    else if (strobe.newPeriod) tickIdx <= '0;
    else if (tickIn)           tickIdx <= (tickIdx == LAST_IDX) ? '0 : tickIdx + 1'b1;
  end

  // armed step restart; a fresh step wins over the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 restartPend <= 1'b0;
    else if (strobe.halt)      restartPend <= 1'b0;
    else if (stepIn)           restartPend <= 1'b1;
    else if (strobe.newPeriod) restartPend <= 1'b0;
  end

  // switch point rounded to the nearest tick
  always_comb begin
    fastTicks  = (PERIOD_TICKS * 32'(decayEighths(decaySel)) + 32'd4) / 32'd8;
    switchTick = SW_W'(PERIOD_TICKS - fastTicks);
  end

  assign pastSwitch   = SW_W'(tickIdx) >= switchTick;
  assign switchAtZero = (switchTick == '0);
  assign wrapDue      = tickIn && ((tickIdx == LAST_IDX) || restartPend);

  generate
    if (BLANK_CYCLES == 0) begin : g_noBlank
      assign blankActive = 1'b0;
    end else begin : g_blank
      localparam int unsigned BL_W = $clog2(BLANK_CYCLES + 1);
      logic [BL_W-1:0] blankCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              blankCnt <= '0;
        else if (strobe.halt)   blankCnt <= '0;
        else if (strobe.reload) blankCnt <= BL_W'(BLANK_CYCLES);
        else if (blankCnt != '0) blankCnt <= blankCnt - 1'b1;
      end
      assign blankActive = (blankCnt != '0);
    end
  endgenerate

endmodule

// File: rtl/chopSeq.sv
module chopSeq
  import chopPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableIn,
  input  logic       tickIn,
  input  logic       nfIn,
  input  logic       rnfIn,
  input  logic       wrapDue,
  input  logic       restartPend,
  input  logic       pastSwitch,
  input  logic       switchAtZero,
  input  logic       blankActive,
  output driveE      driveState,
  output logic       periodStart,
  output ctrlStrobeS strobe
);

  driveE stateQ, stateNxt;

  always_comb begin
    stateNxt = stateQ;
    strobe   = '0;
    if (!enableIn) begin
      stateNxt    = DRV_OFF;
      strobe.halt = 1'b1;
    end else if (tickIn && (wrapDue || stateQ == DRV_OFF)) begin
      strobe.newPeriod = 1'b1;
      if (stateQ == DRV_FAST && !restartPend && rnfIn)
        stateNxt = switchAtZero ? DRV_FAST : DRV_SLOW;
      else
        stateNxt = DRV_CHARGE;
    end else begin
      case (stateQ)
        DRV_CHARGE: if (nfIn && !blankActive)
                      stateNxt = pastSwitch ? DRV_FAST : DRV_SLOW;
        DRV_SLOW:   if (pastSwitch) stateNxt = DRV_FAST;
        default:    stateNxt = stateQ;
      endcase
    end
    strobe.reload = enableIn && (strobe.newPeriod || stateNxt != stateQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= DRV_OFF;
      periodStart <= 1'b0;
    end else begin
      stateQ      <= stateNxt;
      periodStart <= strobe.newPeriod;
    end
  end

  assign driveState = stateQ;

endmodule

// File: rtl/chopCtrl.sv
module chopCtrl
  import chopPkg::*;
#(
  parameter int unsigned PERIOD_TICKS = 8,
  parameter int unsigned BLANK_CYCLES = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       stepIn,
  input  logic       enableIn,
  input  logic [1:0] decaySel,
  input  logic       nfIn,
  input  logic       rnfIn,
  output logic [1:0] driveState,
  output logic       periodStart
);

  ctrlStrobeS strobe;
  driveE      stateE;
  logic       wrapDue, restartPend, pastSwitch, switchAtZero, blankActive;

  chopTimer #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) i_timer (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .stepIn(stepIn),
    .decaySel(decaySel), .strobe(strobe), .wrapDue(wrapDue),
    .restartPend(restartPend), .pastSwitch(pastSwitch),
    .switchAtZero(switchAtZero), .blankActive(blankActive)
  );

  chopSeq i_seq (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .tickIn(tickIn),
    .nfIn(nfIn), .rnfIn(rnfIn), .wrapDue(wrapDue),
    .restartPend(restartPend), .pastSwitch(pastSwitch),
    .switchAtZero(switchAtZero), .blankActive(blankActive),
    .driveState(stateE), .periodStart(periodStart), .strobe(strobe)
  );

  assign driveState = stateE;

endmodule

// File: rtl/chopCtrlChk.sv
module chopCtrlChk #(
  parameter int unsigned BLANK_CYCLES = 30
) (
  input logic       clk,
  input logic       rstN,
  input logic       enableIn,
  input logic       tickIn,
  input logic [1:0] driveState,
  input logic       periodStart
);

  localparam int unsigned CW = $clog2(BLANK_CYCLES + 2);

  logic [1:0]    stateQ;
  logic [CW-1:0] sinceCnt;

  // cycles spent in the current state or period, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= 2'd0;
      sinceCnt <= '0;
    end else begin
      stateQ <= driveState;
      if (periodStart || driveState != stateQ) sinceCnt <= CW'(1);
      else if (sinceCnt < CW'(BLANK_CYCLES))   sinceCnt <= sinceCnt + 1'b1;
    end
  end

  p_off_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |=> driveState == 2'd0);

  p_strobe_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> ($past(tickIn) && $past(enableIn)));

  p_charge_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (periodStart && $past(driveState) != 2'd3) |-> driveState == 2'd1);

  p_fast_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (driveState == 2'd3 && enableIn && !tickIn) |=> driveState == 2'd3);

  p_blank_respected_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(driveState) == 2'd1 && driveState >= 2'd2 && !periodStart)
      |-> $past(sinceCnt) >= CW'(BLANK_CYCLES));

endmodule

bind chopCtrl chopCtrlChk #(.BLANK_CYCLES(BLANK_CYCLES)) i_chk (
  .clk(clk), .rstN(rstN), .enableIn(enableIn), .tickIn(tickIn),
  .driveState(driveState), .periodStart(periodStart)
);

// File: tb/test_chopCtrl.sv
module test_chopCtrl;

  localparam int unsigned PERIOD = 8;
  localparam int unsigned BLANK  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, stepIn = 1'b0, enableIn = 1'b0;
  logic [1:0] decaySel = 2'd0;
  logic nfIn = 1'b0, rnfIn = 1'b0;
  logic [1:0] driveState;
  logic periodStart;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] OFF = 2'd0, CHG = 2'd1, SLW = 2'd2, FST = 2'd3;

  always #5 clk = ~clk;

  chopCtrl #(.PERIOD_TICKS(PERIOD), .BLANK_CYCLES(BLANK)) i_chopCtrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .stepIn(stepIn),
    .enableIn(enableIn), .decaySel(decaySel), .nfIn(nfIn), .rnfIn(rnfIn),
    .driveState(driveState), .periodStart(periodStart)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTick();
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic ticksSettle(input int n);
    for (int i = 0; i < n; i++) begin
      pulseTick();
      idle(1);
    end
  endtask

  // from a fresh period in charge: reach slow, then fast at the switch point
  task automatic reachFast(input int ticksToSwitch);
    nfIn = 1'b1;
    idle(BLANK + 2);
    nfIn = 1'b0;
    ticksSettle(ticksToSwitch);
  endtask

  task automatic tReset();
    chk("R1 reset state", driveState, OFF);
    chk("R1 reset strobe", {1'b0, periodStart}, 2'd0);
    pulseTick(); nfIn = 1'b1; idle(2); nfIn = 1'b0;
    chk("R1 disabled tick stays off", driveState, OFF);
  endtask

  task automatic tChargeBlank();
    enableIn = 1'b1; decaySel = 2'd0;
    idle(1);
    chk("R3 enable alone keeps off", driveState, OFF);
    pulseTick();
    chk("R3 first period charge", driveState, CHG);
    chk("R2 strobe at period start", {1'b0, periodStart}, 2'd1);
    nfIn = 1'b1;
    idle(BLANK);
    chk("R8 nf masked in blanking", driveState, CHG);
    idle(1);
    chk("R4 nf before switch to slow", driveState, SLW);
    chk("R2 strobe one cycle", {1'b0, periodStart}, 2'd0);
  endtask

  task automatic tSlowFast();
    // nf still high: must stay ignored in slow and fast (R10)
    ticksSettle(6);
    chk("R10 nf ignored in slow", driveState, SLW);
    chk("R5 sel00 slow at index 6", driveState, SLW);
    ticksSettle(1);
    chk("R5 sel00 fast at index 7", driveState, FST);
    idle(3);
    chk("R10 nf ignored in fast", driveState, FST);
    nfIn = 1'b0;
  endtask

  task automatic tWrapCancel();
    rnfIn = 1'b0;
    pulseTick();
    chk("R6 no cancel gives charge", driveState, CHG);
    chk("R2 strobe after 8 ticks", {1'b0, periodStart}, 2'd1);
    reachFast(7);
    chk("R5 fast again", driveState, FST);
    rnfIn = 1'b1;
    pulseTick();
    rnfIn = 1'b0;
    chk("R6 cancel starts in slow", driveState, SLW);
    chk("R6 cancel strobe", {1'b0, periodStart}, 2'd1);
    ticksSettle(6);
    chk("R6 cancelled period index restarted", driveState, SLW);
    ticksSettle(1);
    chk("R5 fast after cancel period", driveState, FST);
  endtask

  task automatic tFullFast();
    decaySel = 2'd3;
    pulseTick();
    chk("R3 charge in 100 percent mode", driveState, CHG);
    nfIn = 1'b1; idle(BLANK + 1); nfIn = 1'b0;
    chk("R4 charge to fast at sel11", driveState, FST);
    ticksSettle(7);
    rnfIn = 1'b1;
    pulseTick();
    rnfIn = 1'b0;
    chk("R6 cancel at sel11 stays fast", driveState, FST);
    chk("R6 sel11 cancel strobe", {1'b0, periodStart}, 2'd1);
    ticksSettle(7);
  endtask

  task automatic tQuarter();
    decaySel = 2'd2;
    pulseTick();
    nfIn = 1'b1; idle(BLANK + 2); nfIn = 1'b0;
    chk("R4 sel10 slow at index 0", driveState, SLW);
    ticksSettle(1);
    chk("R5 sel10 slow at index 1", driveState, SLW);
    ticksSettle(1);
    chk("R5 sel10 fast at index 2", driveState, FST);
    ticksSettle(5);
  endtask

  task automatic tLateNf();
    decaySel = 2'd1;
    pulseTick();
    chk("R3 charge sel01", driveState, CHG);
    ticksSettle(6);
    chk("R5 charge held past switch", driveState, CHG);
    nfIn = 1'b1; idle(2); nfIn = 1'b0;
    chk("R4 late nf goes fast", driveState, FST);
  endtask

  task automatic tStep();
    // index 6, fast, sel01
    stepIn = 1'b1; rnfIn = 1'b1;
    @(negedge clk);
    stepIn = 1'b0;
    idle(3);
    chk("R7 no change before tick", driveState, FST);
    chk("R7 no strobe before tick", {1'b0, periodStart}, 2'd0);
    pulseTick();
    rnfIn = 1'b0;
    chk("R7 restart in charge", driveState, CHG);
    chk("R7 restart strobe", {1'b0, periodStart}, 2'd1);
    nfIn = 1'b1; idle(BLANK + 2); nfIn = 1'b0;
    ticksSettle(4);
    chk("R7 index restarted at zero", driveState, SLW);
    ticksSettle(1);
    chk("R5 sel01 fast at index 5", driveState, FST);
  endtask

  task automatic tDisable();
    enableIn = 1'b0;
    idle(1);
    chk("R9 disable forces off", driveState, OFF);
    nfIn = 1'b1; pulseTick(); idle(2); nfIn = 1'b0;
    chk("R9 ticks ignored while disabled", driveState, OFF);
    enableIn = 1'b1;
    idle(2);
    chk("R9 off until tick", driveState, OFF);
    pulseTick();
    chk("R9 re-enable charge", driveState, CHG);
    chk("R9 re-enable strobe", {1'b0, periodStart}, 2'd1);
    nfIn = 1'b1; idle(BLANK + 2); nfIn = 1'b0;
    ticksSettle(4);
    chk("R9 index cleared", driveState, SLW);
    ticksSettle(1);
    chk("R9 fast at index 5", driveState, FST);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    tReset();
    tChargeBlank();
    tSlowFast();
    tWrapCancel();
    tFullFast();
    tQuarter();
    tLateNf();
    tStep();
    tDisable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule